// File: doc/BRIEF.md
# DRAM Page-Tracking Access Sequencer

This block sits in a main memory controller and serves four-beat burst requests to synchronous DRAM. For every bank it records whether a row is open and which row that is. Each request is sorted into one of three classes. A page hit finds its row already open. A row miss finds the bank closed. A page miss finds a different row open. The block then issues the commands that class needs on an abstract SDRAM command bus: precharge, activate, and one read or write column command. It also marks the four data beats with a bus-clock-accurate latency.

The first data beat follows acceptance by 5 clocks on a hit, by 8 on a row miss and by 11 on a page miss. Each extra command step costs 3 clocks. The later beats follow every 2 clocks. Only one burst is in flight at a time, and a new request is taken only once the fourth beat is done. A refresh-pending input, honoured while idle, closes every bank. After it, the next access to any bank is a row miss.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, ready_o is 1, cmd_o is NOP (0), beat_o is 0, and every bank is closed.
- R2: kind_o gives the class of the accepted burst from the cycle after acceptance until the burst ends: 0 = page hit (same row open), 1 = row miss (bank closed), 2 = page miss (other row open).
- R3: On a page hit, the column command comes 1 clock after acceptance and the first beat 5 clocks after acceptance.
- R4: On a row miss, ACT comes at 1 clock, the column command at 4 and the first beat at 8 clocks after acceptance.
- R5: On a page miss, PRE comes at 1 clock, ACT at 4, the column command at 7 and the first beat at 11 clocks after acceptance.
- R6: Each burst gives exactly four single-cycle beat_o pulses, 2 clocks apart, with beat_idx_o counting 0, 1, 2, 3.
- R7: ready_o is 0 from the cycle after acceptance through the fourth-beat cycle. Requests made in that time are ignored and change no bank state. ready_o is 1 in the next cycle.
- R8: While idle, refresh_i drives ready_o to 0 and closes all banks.
- R9: The column command is RD (3) when req_we_i was 0 at acceptance and WR (4) when it was 1. PRE is 1, ACT is 2 and NOP is 0.
- R10: Opening or closing a row in one bank leaves the open-row state of every other bank unchanged.
- R11: cmd_bank_o holds the request bank. cmd_addr_o carries the row during ACT and the zero-extended column during RD or WR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst request, taken when ready_o is high |
| req_we_i | input | 1 | 1 = write burst, 0 = read burst |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Starting column |
| refresh_i | input | 1 | Refresh pending; closes all banks while idle |
| ready_o | output | 1 | Sequencer can take a request |
| cmd_o | output | 3 | Command: 0 NOP, 1 PRE, 2 ACT, 3 RD, 4 WR |
| cmd_bank_o | output | BANK_W | Bank for the current command |
| cmd_addr_o | output | ROW_W | Row on ACT, column on RD/WR |
| beat_o | output | 1 | Data beat cycle |
| beat_idx_o | output | IDX_W | Beat number in the burst |
| kind_o | output | 2 | Class of the current burst |

## Verification
The requests are ordered so that each class comes out in turn from the tracked state:
- a fresh bank gives a row miss;
- a repeat to the same row gives a hit;
- a new row in an open bank gives a page miss.

Going back to one bank after work in another shows that the banks are kept apart. The top row and column addresses test the field widths. A refresh between bursts turns what would have been hits into row misses. A request held high for a whole burst with a different row shows that requests made while busy are dropped. The following access still hits the first row.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_ROWMISS  = 2'd1,
    KIND_PAGEMISS = 2'd2
  } kind_e;
endpackage

// File: rtl/dps_bank_table.sv
module dps_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_all_i,
  input  logic              close_i,
  input  logic              open_i,
  input  logic [BANK_W-1:0] upd_bank_i,
  input  logic [ROW_W-1:0]  upd_row_i,
  input  logic [BANK_W-1:0] lk_bank_i,
  input  logic [ROW_W-1:0]  lk_row_i,
  output logic [1:0]        lk_kind_o
);
  import dps_pkg::*;

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (upd_bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (clear_all_i || (close_i && sel)) begin
        open_q[b] <= 1'b0;
      end else if (open_i && sel) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row_i;
      end
    end
  end

  always_comb begin
    if (!open_q[lk_bank_i])                lk_kind_o = KIND_ROWMISS;
    else if (row_q[lk_bank_i] == lk_row_i) lk_kind_o = KIND_HIT;
    else                                   lk_kind_o = KIND_PAGEMISS;
  end
endmodule

// File: rtl/dps_seq_timer.sv
module dps_seq_timer #(
  parameter int T_HIT   = 5,
  parameter int T_STEP  = 3,
  parameter int T_BEAT  = 2,
  parameter int BEATS   = 4,
  localparam int IDX_W  = $clog2(BEATS),
  localparam int CNT_W  = $clog2(T_HIT + 2*T_STEP + T_BEAT*(BEATS-1) + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       steps_i,
  output logic             busy_o,
  output logic             pre_o,
  output logic             act_o,
  output logic             xfer_o,
  output logic             beat_o,
  output logic [IDX_W-1:0] beat_idx_o
);
  logic [CNT_W-1:0] cyc_q, step_off, lat, d;
  logic [1:0]       steps_q;
  logic             last;

  assign busy_o   = (cyc_q != '0);
  assign step_off = CNT_W'(T_STEP) * CNT_W'(steps_q);
  assign lat      = CNT_W'(T_HIT) + step_off;
  assign d        = cyc_q - lat;

  assign pre_o  = busy_o && (steps_q == 2'd2) && (cyc_q == CNT_W'(1));
  assign act_o  = busy_o && (steps_q != 2'd0) &&
                  (cyc_q == CNT_W'(1) + step_off - CNT_W'(T_STEP));
  assign xfer_o = busy_o && (cyc_q == CNT_W'(1) + step_off);

  // beats from lat on, every T_BEAT clocks
  assign beat_o     = busy_o && (cyc_q >= lat) &&
                      ((d % CNT_W'(T_BEAT)) == '0) &&
                      (d < CNT_W'(T_BEAT * BEATS));
  assign beat_idx_o = IDX_W'(d / CNT_W'(T_BEAT));
  assign last       = beat_o && (beat_idx_o == IDX_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      steps_q <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        cyc_q   <= CNT_W'(1);
        steps_q <= steps_i;
      end
    end else if (last) begin
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int BEATS     = 4,
  parameter int T_HIT     = 5,
  parameter int T_STEP    = 3,
  parameter int T_BEAT    = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              refresh_i,
  output logic              ready_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_addr_o,
  output logic              beat_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic [1:0]        kind_o
);
  import dps_pkg::*;

  logic              busy, pre, act, xfer, accept;
  logic [1:0]        lk_kind;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [1:0]        kind_q;

  assign ready_o = !busy && !refresh_i;
  assign accept  = req_i && ready_o;

  dps_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_all_i (!busy && refresh_i),
    .close_i     (pre),
    .open_i      (act),
    .upd_bank_i  (bank_q),
    .upd_row_i   (row_q),
    .lk_bank_i   (req_bank_i),
    .lk_row_i    (req_row_i),
    .lk_kind_o   (lk_kind)
  );

  // kind code doubles as the number of extra command steps
  dps_seq_timer #(
    .T_HIT  (T_HIT),
    .T_STEP (T_STEP),
    .T_BEAT (T_BEAT),
    .BEATS  (BEATS)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .steps_i    (lk_kind),
    .busy_o     (busy),
    .pre_o      (pre),
    .act_o      (act),
    .xfer_o     (xfer),
    .beat_o     (beat_o),
    .beat_idx_o (beat_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      we_q   <= 1'b0;
      kind_q <= KIND_HIT;
    end else if (accept) begin
      bank_q <= req_bank_i;
      row_q  <= req_row_i;
      col_q  <= req_col_i;
      we_q   <= req_we_i;
      kind_q <= lk_kind;
    end
  end

  always_comb begin
    cmd_o      = CMD_NOP;
    cmd_addr_o = '0;
    if (pre) begin
      cmd_o = CMD_PRE;
    end else if (act) begin
      cmd_o      = CMD_ACT;
      cmd_addr_o = row_q;
    end else if (xfer) begin
      cmd_o      = we_q ? CMD_WR : CMD_RD;
      cmd_addr_o = ROW_W'(col_q);
    end
  end

  assign cmd_bank_o = bank_q;
  assign kind_o     = kind_q;
endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk #(
  parameter int BEATS  = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             refresh_i,
  input logic             ready_o,
  input logic [2:0]       cmd_o,
  input logic             beat_o,
  input logic [IDX_W-1:0] beat_idx_o
);
  import dps_pkg::*;

  // delays below match the default timing (T_HIT 5, T_STEP 3, T_BEAT 2)
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cmd_o == CMD_NOP && !beat_o));

  a_r8_refresh_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |-> !ready_o);

  a_r5_pre_then_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |=> ##2 (cmd_o == CMD_ACT));

  a_r4_act_then_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |=> ##2 (cmd_o == CMD_RD || cmd_o == CMD_WR));

  a_r3_col_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |=> ##3 (beat_o && beat_idx_o == '0));

  a_r6_beat_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |=> !beat_o);

  a_r6_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && beat_idx_o != IDX_W'(BEATS - 1)) |=> ##1
      (beat_o && beat_idx_o == IDX_W'($past(beat_idx_o, 2) + 1'b1)));
endmodule

bind dram_page_seq dram_page_seq_chk #(.BEATS(BEATS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .refresh_i  (refresh_i),
  .ready_o    (ready_o),
  .cmd_o      (cmd_o),
  .beat_o     (beat_o),
  .beat_idx_o (beat_idx_o)
);

// File: tb/sim_dram_page_seq.sv
`timescale 1ns/1ps
module sim_dram_page_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, refresh = 1'b0;
  logic [1:0]  bank = '0;
  logic [11:0] row = '0;
  logic [7:0]  col = '0;
  logic        ready, beat;
  logic [2:0]  cmd;
  logic [1:0]  cmd_bank, beat_idx, kind;
  logic [11:0] cmd_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_page_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(we),
    .req_bank_i(bank), .req_row_i(row), .req_col_i(col), .refresh_i(refresh),
    .ready_o(ready), .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
    .beat_o(beat), .beat_idx_o(beat_idx), .kind_o(kind)
  );

  typedef struct packed {
    logic [1:0]  bank;
    logic [11:0] row;
    logic [7:0]  col;
    logic        we;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'd5,    8'd3,   1'b0, 2'd1},  // closed bank
    '{2'd0, 12'd5,    8'd7,   1'b1, 2'd0},  // same row
    '{2'd0, 12'd9,    8'd1,   1'b0, 2'd2},  // other row
    '{2'd1, 12'd9,    8'd2,   1'b1, 2'd1},
    '{2'd0, 12'd9,    8'd4,   1'b0, 2'd0},  // R10: bank 0 row survives bank 1 activity
    '{2'd1, 12'd3,    8'd0,   1'b0, 2'd2},
    '{2'd3, 12'd4095, 8'd255, 1'b1, 2'd1},  // top addresses
    '{2'd3, 12'd4095, 8'd0,   1'b0, 2'd0}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic report();
    if (done) return;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Drive one burst and check every cycle until ready returns.
  task automatic run_burst(input logic [1:0] b, input logic [11:0] r, input logic [7:0] c,
                           input logic w, input int s, input bit hold_busy);
    int lat, lastk, cmd_err, dir_err, beat_err, rdy_err, addr_err, nbeats;
    string trq;
    lat = 5 + 3*s;
    lastk = lat + 6;
    cmd_err = 0; dir_err = 0; beat_err = 0; rdy_err = 0; addr_err = 0; nbeats = 0;
    trq = (s == 0) ? "R3" : (s == 1) ? "R4" : "R5";
    @(negedge clk);
    check(ready === 1'b1, "R7 ready before request", int'(ready), 1);
    req = 1'b1; bank = b; row = r; col = c; we = w;
    @(posedge clk);
    #1;
    if (hold_busy) row = r + 12'd1;
    else req = 1'b0;
    for (int k = 1; k <= lastk + 1; k++) begin
      int ec;
      bit eb;
      @(negedge clk);
      if (k == 1) check(kind === 2'(s), "R2 burst class", int'(kind), s);
      if (s == 2 && k == 1)                 ec = 1;
      else if (s >= 1 && k == 1 + 3*(s-1)) ec = 2;
      else if (k == 1 + 3*s)               ec = w ? 4 : 3;
      else                                  ec = 0;
      if (k == 1 + 3*s) begin
        if (cmd !== 3'(ec)) dir_err++;
        if (cmd_addr !== 12'(c) || cmd_bank !== b) addr_err++;
      end else if (cmd !== 3'(ec)) cmd_err++;
      if (ec == 2 && (cmd_addr !== r || cmd_bank !== b)) addr_err++;
      eb = (k >= lat) && ((k - lat) % 2 == 0) && ((k - lat) / 2 < 4);
      if (beat !== eb) beat_err++;
      if (eb) begin
        if (beat_idx !== 2'((k - lat) / 2)) beat_err++;
        nbeats++;
      end
      if (k <= lastk) begin
        if (ready !== 1'b0) rdy_err++;
      end else begin
        check(ready === 1'b1, "R7 ready after fourth beat", int'(ready), 1);
      end
      if (k == lastk) req = 1'b0;
    end
    check(cmd_err == 0, {trq, " command timing errors"}, cmd_err, 0);
    check(dir_err == 0, "R9 column command direction", dir_err, 0);
    check(beat_err == 0 && nbeats == 4, "R6 beat pattern errors", beat_err, 0);
    check(rdy_err == 0, "R7 ready low while busy", rdy_err, 0);
    check(addr_err == 0, "R11 command bank/address errors", addr_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1, "R1 reset ready", int'(ready), 1);
    check(cmd === 3'd0, "R1 reset command", int'(cmd), 0);
    check(beat === 1'b0, "R1 reset beat", int'(beat), 0);

    // Table walk: R2 through R6, R9, R10, R11
    for (int i = 0; i < NV; i++)
      run_burst(VECS[i].bank, VECS[i].row, VECS[i].col, VECS[i].we, int'(VECS[i].kind), 1'b0);

    // R8: refresh while idle closes all banks
    @(negedge clk);
    refresh = 1'b1;
    #1;
    check(ready === 1'b0, "R8 ready low during refresh", int'(ready), 0);
    @(negedge clk);
    refresh = 1'b0;
    run_burst(2'd0, 12'd9, 8'd5, 1'b0, 1, 1'b0);     // R8: was open, now row miss
    run_burst(2'd3, 12'd4095, 8'd6, 1'b1, 1, 1'b0);  // R8

    // R7: request held during busy with a different row is dropped
    run_burst(2'd2, 12'd1, 8'd9, 1'b0, 1, 1'b1);
    run_burst(2'd2, 12'd1, 8'd10, 1'b0, 0, 1'b0);    // still a hit on row 1

    report();
  end
endmodule